// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block writes received frames into a circular buffer held in a local packet RAM. The RAM is divided into 256-byte pages, and the ring covers the pages from a programmable first page up to, but not including, a programmable stop page. Frame bytes arrive one per cycle on a byte stream that carries start-of-frame and end-of-frame markers. The block places each frame's data four bytes into the current page, after a reserved 4-byte header, and continues into the following pages as needed, wrapping from the last ring page back to the first.

Once the final byte is in, the block writes the header at offset 0 of the frame's first page. The header holds a status byte, the page where the next frame will start, and the stored byte count. The block then moves the current-page pointer on. The host owns a boundary page, which marks data it has not yet read. The block never writes into that page. If a frame would need it, the frame is dropped, an overwrite event is signalled and a sticky reset-status flag is raised. The flag stays set until the host moves the boundary.

In monitor mode nothing is stored, and every frame counts as missed. After each end-of-frame the source keeps `rx_valid` low for at least four cycles while the header is written. Bytes offered during that window are not stored.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset, no RAM write is issued, `cur_page` is 0, `miss_count` is 0, and `rst_stat`, `frame_done`, `ovw_pulse` and `miss_pulse` are all low.
- R2: Data byte j (counting from 0) of a stored frame is written at linear byte position 4+j from the start of the current page. Positions past offset 255 continue at offset 0 of the next ring page.
- R3: After the last data byte, four header bytes are written at offsets 0, 1, 2 and 3 of the frame's first page, in this order: status, next-frame page, count low byte, count high byte. The count equals the frame length plus 4. In the status byte, bit0 means no CRC and no alignment error, bit1 means CRC error (also set on an alignment error), bit2 means alignment error, and bit5 means group-address match. Bits 3, 4, 6 and 7 are 0 for stored frames. `frame_done` pulses in the cycle the last header byte is written.
- R4: The next-frame page is the ring page after the last page that holds frame bytes. When the frame fills its last page exactly, it is the page the pointer has already stepped into. `cur_page` takes this value only together with `frame_done`.
- R5: The page after (stop page − 1) is the first page. The stop page is never written.
- R6: If a frame needs the boundary page, it is dropped. `ovw_pulse` and `miss_pulse` fire, `rst_stat` is set, and `cur_page` is unchanged. `rst_stat` stays set until `cfg_bound` differs from its value at the overflow, and then it clears on the next cycle.
- R7: A frame whose end byte carries `rx_abort` writes no header, leaves `cur_page` unchanged and is not counted as missed.
- R8: With `cfg_monitor` high at start of frame, the frame causes no RAM write and leaves `cur_page` unchanged, and `miss_pulse` fires once.
- R9: `miss_count` rises by one for each missed frame and holds at its all-ones value.
- R10: A pulse on `cur_ld` while no frame is in progress loads `cur_ld_page` into `cur_page`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ring_first | input | PAGE_W | First page of the ring |
| cfg_ring_stop | input | PAGE_W | Page just past the ring |
| cfg_bound | input | PAGE_W | Host boundary page (oldest unread) |
| cfg_monitor | input | 1 | Check frames without storing them |
| cur_ld | input | 1 | Load the current page |
| cur_ld_page | input | PAGE_W | Value for the current page |
| rx_valid | input | 1 | Byte present on rx_data |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_crc_err | input | 1 | CRC error, valid with rx_eof |
| rx_align_err | input | 1 | Alignment error, valid with rx_eof |
| rx_abort | input | 1 | Discard frame, valid with rx_eof |
| rx_group | input | 1 | Group-address match, valid with rx_eof |
| ram_we | output | 1 | Packet RAM write strobe |
| ram_addr | output | PAGE_W+OFS_W | Packet RAM byte address {page, offset} |
| ram_wdata | output | 8 | Packet RAM write data |
| cur_page | output | PAGE_W | Page where the next frame starts |
| frame_done | output | 1 | Frame stored, header complete |
| ovw_pulse | output | 1 | Overwrite of unread data avoided |
| miss_pulse | output | 1 | Frame missed |
| rst_stat | output | 1 | Sticky overwrite state |
| miss_count | output | MISS_W | Saturating missed-frame count |

## Verification
Every stored frame is checked byte by byte in a shadow of the packet RAM. A wrong page step or wrap shows up as a misplaced data byte within the same frame. A wrong stored length or status shows up as a bad header byte within four cycles of the end byte. A corrupted current page shows up on `cur_page` and in where the next frame lands. The overflow and abort tests confirm that `cur_page` keeps its earlier value. Monitor and saturation runs check the missed count at the port.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    typedef enum logic [1:0] {
        RXR_IDLE = 2'd0,
        RXR_DATA = 2'd1,
        RXR_DROP = 2'd2,
        RXR_HDR  = 2'd3
    } rxr_state_e;

    localparam int RXR_HDR_BYTES = 4;
    localparam int RXR_ST_OK     = 0;
    localparam int RXR_ST_CRC    = 1;
    localparam int RXR_ST_ALIGN  = 2;
    localparam int RXR_ST_GROUP  = 5;
endpackage

// File: rtl/rxr_page_step.sv
module rxr_page_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] page_i,
    input  logic [PAGE_W-1:0] first_i,
    input  logic [PAGE_W-1:0] stop_i,
    output logic [PAGE_W-1:0] next_o
);
    logic [PAGE_W-1:0] inc;

    always_comb begin
        inc    = page_i + 1'b1;
        next_o = (inc == stop_i) ? first_i : inc;
    end
endmodule

// File: rtl/rxr_hdr_sel.sv
module rxr_hdr_sel #(
    parameter int PAGE_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic [1:0]        idx_i,
    input  logic [7:0]        stat_i,
    input  logic [PAGE_W-1:0] next_i,
    input  logic [LEN_W-1:0]  count_i,
    output logic [7:0]        byte_o
);
    always_comb begin
        case (idx_i)
            2'd0:    byte_o = stat_i;
            2'd1:    byte_o = 8'(next_i);
            2'd2:    byte_o = count_i[7:0];
            default: byte_o = 8'(count_i >> 8);
        endcase
    end
endmodule

// File: rtl/rxr_sat_count.sv
module rxr_sat_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] count_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc_i && cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;

    AST_MISS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) |=> (cnt_q == TOP)); // R9
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && cnt_q != TOP) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 8,
    parameter int LEN_W  = 16,
    parameter int MISS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PAGE_W-1:0]       cfg_ring_first,
    input  logic [PAGE_W-1:0]       cfg_ring_stop,
    input  logic [PAGE_W-1:0]       cfg_bound,
    input  logic                    cfg_monitor,
    input  logic                    cur_ld,
    input  logic [PAGE_W-1:0]       cur_ld_page,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic                    rx_crc_err,
    input  logic                    rx_align_err,
    input  logic                    rx_abort,
    input  logic                    rx_group,
    output logic                    ram_we,
    output logic [PAGE_W+OFS_W-1:0] ram_addr,
    output logic [7:0]              ram_wdata,
    output logic [PAGE_W-1:0]       cur_page,
    output logic                    frame_done,
    output logic                    ovw_pulse,
    output logic                    miss_pulse,
    output logic                    rst_stat,
    output logic [MISS_W-1:0]       miss_count
);
    localparam int ADDR_W = PAGE_W + OFS_W;
    localparam logic [OFS_W-1:0] DATA_OFS = OFS_W'(RXR_HDR_BYTES);
    localparam logic [LEN_W-1:0] HDR_ADD  = LEN_W'(RXR_HDR_BYTES);

    typedef struct packed {
        rxr_state_e        st;
        logic [PAGE_W-1:0] cur;
        logic [PAGE_W-1:0] wpg;
        logic [OFS_W-1:0]  wofs;
        logic [PAGE_W-1:0] nxt;
        logic [LEN_W-1:0]  len;
        logic [1:0]        hidx;
        logic [7:0]        stat;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              done;
        logic              ovw;
        logic              miss;
        logic              rst_flag;
        logic [PAGE_W-1:0] bnd_snap;
    } rxr_state_t;

    rxr_state_t s_d, s_q;

    logic [PAGE_W-1:0] pos_pg, step_pg, new_pg;
    logic [OFS_W-1:0]  pos_ofs, ofs_inc;
    logic [LEN_W-1:0]  len_new;
    logic              wrap, accept, need_step, hit_bound;
    logic [7:0]        stat_now, hdr_byte;
    logic              bad_fcs;

    rxr_page_step #(.PAGE_W(PAGE_W)) u_step (
        .page_i (pos_pg),
        .first_i(cfg_ring_first),
        .stop_i (cfg_ring_stop),
        .next_o (step_pg)
    );

    rxr_hdr_sel #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_hdr (
        .idx_i  (s_q.hidx),
        .stat_i (s_q.stat),
        .next_i (s_q.nxt),
        .count_i(s_q.len),
        .byte_o (hdr_byte)
    );

    rxr_sat_count #(.W(MISS_W)) u_miss (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (s_q.miss),
        .count_o(miss_count)
    );

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        s_d.done = 1'b0;
        s_d.ovw  = 1'b0;
        s_d.miss = 1'b0;

        if (s_q.rst_flag && cfg_bound != s_q.bnd_snap) s_d.rst_flag = 1'b0;

        // byte position of the next incoming data byte
        pos_pg    = (s_q.st == RXR_IDLE) ? s_q.cur  : s_q.wpg;
        pos_ofs   = (s_q.st == RXR_IDLE) ? DATA_OFS : s_q.wofs;
        len_new   = ((s_q.st == RXR_IDLE) ? '0 : s_q.len) + 1'b1;
        ofs_inc   = pos_ofs + 1'b1;
        wrap      = (ofs_inc == '0);
        new_pg    = wrap ? step_pg : pos_pg;
        need_step = wrap || (rx_eof && !rx_abort);
        hit_bound = need_step && (step_pg == cfg_bound);

        bad_fcs  = rx_crc_err | rx_align_err;
        stat_now = '0;
        stat_now[RXR_ST_OK]    = !bad_fcs;
        stat_now[RXR_ST_CRC]   = bad_fcs;
        stat_now[RXR_ST_ALIGN] = rx_align_err;
        stat_now[RXR_ST_GROUP] = rx_group;

        accept = rx_valid && (((s_q.st == RXR_IDLE) && rx_sof && !cfg_monitor)
                              || (s_q.st == RXR_DATA));

        case (s_q.st)
            RXR_IDLE: begin
                if (cur_ld) s_d.cur = cur_ld_page;
                if (rx_valid && rx_sof && cfg_monitor) begin
                    s_d.miss = 1'b1;
                    if (!rx_eof) s_d.st = RXR_DROP;
                end
            end
            RXR_DROP: begin
                if (rx_valid && rx_eof) s_d.st = RXR_IDLE;
            end
            RXR_HDR: begin
                s_d.we    = 1'b1;
                s_d.addr  = {s_q.cur, OFS_W'(s_q.hidx)};
                s_d.wdata = hdr_byte;
                s_d.hidx  = s_q.hidx + 2'd1;
                if (s_q.hidx == 2'd3) begin
                    s_d.st   = RXR_IDLE;
                    s_d.cur  = s_q.nxt;
                    s_d.done = 1'b1;
                end
            end
            default: ;
        endcase

        if (accept) begin
            s_d.we    = 1'b1;
            s_d.addr  = {pos_pg, pos_ofs};
            s_d.wdata = rx_data;
            s_d.len   = len_new;
            s_d.wpg   = new_pg;
            s_d.wofs  = ofs_inc;
            if (hit_bound) begin
                s_d.ovw      = 1'b1;
                s_d.miss     = 1'b1;
                s_d.rst_flag = 1'b1;
                s_d.bnd_snap = cfg_bound;
                s_d.st       = rx_eof ? RXR_IDLE : RXR_DROP;
            end else if (rx_eof) begin
                if (rx_abort) begin
                    s_d.st = RXR_IDLE;
                end else begin
                    s_d.st   = RXR_HDR;
                    s_d.nxt  = step_pg;
                    s_d.stat = stat_now;
                    s_d.len  = len_new + HDR_ADD;
                    s_d.hidx = 2'd0;
                end
            end else begin
                s_d.st = RXR_DATA;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ram_we     = s_q.we;
    assign ram_addr   = s_q.addr;
    assign ram_wdata  = s_q.wdata;
    assign cur_page   = s_q.cur;
    assign frame_done = s_q.done;
    assign ovw_pulse  = s_q.ovw;
    assign miss_pulse = s_q.miss;
    assign rst_stat   = s_q.rst_flag;

    AST_NO_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr[ADDR_W-1:OFS_W] != cfg_ring_stop)); // R5
    AST_CUR_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_page != $past(cur_page)) |-> (frame_done || $past(cur_ld))); // R4
    AST_OVW_SETS_RST: assert property (@(posedge clk) disable iff (!rst_n)
        ovw_pulse |-> (rst_stat && miss_pulse)); // R6
    AST_DONE_AT_HDR_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (ram_we && ram_addr[OFS_W-1:0] == OFS_W'(3)
                        && ram_addr[ADDR_W-1:OFS_W] == $past(cur_page))); // R3
endmodule

// File: tb/rx_ring_mgr_tb_top.sv
module rx_ring_mgr_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FIRST = 8'h10;
    localparam int STOP  = 8'h18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cfg_ring_first = 8'(FIRST), cfg_ring_stop = 8'(STOP), cfg_bound = 8'(FIRST);
    logic cfg_monitor = 1'b0, cur_ld = 1'b0;
    logic [7:0] cur_ld_page = '0;
    logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_crc_err = 0, rx_align_err = 0, rx_abort = 0, rx_group = 0;
    logic [7:0] rx_data = '0;
    logic ram_we, frame_done, ovw_pulse, miss_pulse, rst_stat;
    logic [15:0] ram_addr;
    logic [7:0] ram_wdata, cur_page, miss_count;

    int checks = 0, errors = 0;
    int n_wr = 0, n_ovw = 0, n_miss = 0, n_done = 0, n_stop_wr = 0;
    int exp_cur = 0, exp_miss = 0;
    logic [7:0] mem [int];

    rx_ring_mgr dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n) begin
        if (ram_we) begin
            mem[int'(ram_addr)] = ram_wdata;
            n_wr++;
            if (ram_addr[15:8] == 8'(STOP)) n_stop_wr++;
        end
        if (ovw_pulse)  n_ovw++;
        if (miss_pulse) n_miss++;
        if (frame_done) n_done++;
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int step(int p);
        return (((p + 1) & 255) == STOP) ? FIRST : ((p + 1) & 255);
    endfunction

    function automatic int prev(int p);
        return (p == FIRST) ? STOP - 1 : p - 1;
    endfunction

    function automatic int pat(int seed, int i);
        return (seed * 13 + i * 7 + (i >> 3)) & 255;
    endfunction

    // outcome of storing len bytes from page cur under boundary bnd
    function automatic void plan(int cur, int len, int bnd, output int ovf, output int nxt);
        int pg = cur, ofs = 4;
        ovf = 0; nxt = cur;
        for (int i = 0; i < len; i++) begin
            ofs++;
            if (ofs == 256) begin
                ofs = 0; pg = step(pg);
                if (pg == bnd) begin ovf = 1; return; end
            end
        end
        if (ofs != 0) begin
            nxt = step(pg);
            if (nxt == bnd) ovf = 1;
        end else nxt = pg;
    endfunction

    task automatic send(int len, bit crc, bit fae, bit abrt, bit grp, int seed);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1);
            rx_data = 8'(pat(seed, i));
            rx_crc_err = crc; rx_align_err = fae; rx_abort = abrt; rx_group = grp;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_crc_err = 0; rx_align_err = 0; rx_abort = 0; rx_group = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic load_cur(int p);
        @(negedge clk); cur_ld = 1; cur_ld_page = 8'(p);
        @(negedge clk); cur_ld = 0;
        exp_cur = p;
    endtask

    task automatic bump_miss();
        if (exp_miss < 255) exp_miss++;
    endtask

    // stored frame with full checks of header, data and pointer
    task automatic good_frame(int len, bit crc, bit fae, bit grp, int seed);
        int ovf, nxt, d0, st, pg, off, bad;
        plan(exp_cur, len, int'(cfg_bound), ovf, nxt);
        mem.delete();
        d0 = n_done;
        send(len, crc, fae, 1'b0, grp, seed);
        if (ovf) begin
            chk("R6 overflow seen", n_ovw > 0 ? 1 : 0, 1);
            bump_miss();
            return;
        end
        st = ((crc | fae) ? 0 : 1) | ((crc | fae) ? 2 : 0) | (fae ? 4 : 0) | (grp ? 32 : 0);
        chk("R3 status byte", mem.exists(exp_cur*256) ? int'(mem[exp_cur*256]) : -1, st);
        chk("R3 next page byte", mem.exists(exp_cur*256+1) ? int'(mem[exp_cur*256+1]) : -1, nxt);
        chk("R3 count low", mem.exists(exp_cur*256+2) ? int'(mem[exp_cur*256+2]) : -1, (len + 4) & 255);
        chk("R3 count high", mem.exists(exp_cur*256+3) ? int'(mem[exp_cur*256+3]) : -1, (len + 4) >> 8);
        chk("R3 one done pulse", n_done - d0, 1);
        bad = -1;
        for (int j = 0; j < len; j++) begin
            pg = exp_cur; off = 4 + j;
            while (off >= 256) begin off -= 256; pg = step(pg); end
            if (bad < 0 && (!mem.exists(pg*256+off) || int'(mem[pg*256+off]) != pat(seed, j))) bad = j;
        end
        chk("R2 first misplaced data byte (-1 none)", bad, -1);
        chk("R4 current page", int'(cur_page), nxt);
        exp_cur = nxt;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        finish_run();
    end

    initial begin
        int w0, m0, d0, o0, c0;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ram_we", int'(ram_we), 0);
        chk("R1 cur_page", int'(cur_page), 0);
        chk("R1 miss_count", int'(miss_count), 0);
        chk("R1 rst_stat", int'(rst_stat), 0);
        chk("R1 pulses", int'({frame_done, ovw_pulse, miss_pulse}), 0);

        load_cur(8'h11);
        chk("R10 loaded page", int'(cur_page), 8'h11);

        good_frame(60, 0, 0, 0, 1);          // R2 R3 R4 simple
        good_frame(252, 0, 0, 0, 2);         // R4 exact page fill
        cfg_bound = 8'(prev(exp_cur));
        good_frame(10, 1, 0, 0, 3);          // R3 crc
        cfg_bound = 8'(prev(exp_cur));
        good_frame(10, 0, 1, 0, 4);          // R3 alignment
        cfg_bound = 8'(prev(exp_cur));
        good_frame(10, 0, 0, 1, 5);          // R3 group match

        load_cur(STOP - 1);                  // R5 wrap to first page
        cfg_bound = 8'(prev(exp_cur));
        good_frame(300, 0, 0, 0, 6);
        chk("R5 wrapped next page", exp_cur, FIRST + 1);

        // R7 abort
        m0 = n_miss; d0 = n_done; c0 = exp_cur;
        send(50, 0, 0, 1, 0, 7);
        chk("R7 cur unchanged", int'(cur_page), c0);
        chk("R7 no header", n_done - d0, 0);
        chk("R7 not missed", n_miss - m0, 0);

        // R8 monitor mode
        cfg_monitor = 1; w0 = n_wr; m0 = n_miss;
        send(40, 0, 0, 0, 0, 8);
        cfg_monitor = 0; bump_miss();
        chk("R8 no writes", n_wr - w0, 0);
        chk("R8 one miss", n_miss - m0, 1);
        chk("R8 cur unchanged", int'(cur_page), c0);
        chk("R9 miss_count", int'(miss_count), exp_miss);

        // R6 overflow against boundary
        load_cur(8'h12); cfg_bound = 8'h14;
        o0 = n_ovw; m0 = n_miss; d0 = n_done;
        send(600, 0, 0, 0, 0, 9);
        bump_miss();
        chk("R6 ovw pulse", n_ovw - o0, 1);
        chk("R6 miss pulse", n_miss - m0, 1);
        chk("R6 no done", n_done - d0, 0);
        chk("R6 cur unchanged", int'(cur_page), 8'h12);
        repeat (5) @(negedge clk);
        chk("R6 rst_stat held", int'(rst_stat), 1);
        cfg_bound = 8'h15;
        repeat (2) @(negedge clk);
        chk("R6 rst_stat cleared", int'(rst_stat), 0);
        good_frame(20, 0, 0, 0, 10);
        chk("R4 after overflow", exp_cur, 8'h13);

        // random phase
        for (int k = 0; k < 40; k++) begin
            int len = 1 + int'($urandom_range(699));
            bit crc = ($urandom_range(5) == 0);
            bit fae = ($urandom_range(7) == 0);
            bit grp = ($urandom_range(3) == 0);
            cfg_bound = 8'(prev(exp_cur));
            if ($urandom_range(7) == 0) begin
                d0 = n_done;
                send(len, crc, fae, 1'b1, grp, 100 + k);
                chk("R7 random abort keeps page", int'(cur_page), exp_cur);
                chk("R7 random abort no done", n_done - d0, 0);
            end else begin
                good_frame(len, crc, fae, grp, 100 + k);
            end
        end
        chk("R9 miss_count before saturation", int'(miss_count), exp_miss);

        // R9 saturation
        cfg_monitor = 1;
        for (int k = 0; k < 260; k++) begin
            send(1, 0, 0, 0, 0, k);
            bump_miss();
        end
        cfg_monitor = 0;
        chk("R9 saturated count", int'(miss_count), 255);
        chk("R5 stop page writes", n_stop_wr, 0);
        finish_run();
    end
endmodule